// File: doc/BRIEF.md
# Timer Output-Compare Channel Pair

This block turns the running value of an external timer counter into two reference waveforms. The counter value, its direction and its update-event pulse come from outside, and so does an external clear request. Each channel compares the counter with its own compare value and shapes its reference output with one of eight behaviours: frozen, set on match, reset on match, toggle on match, forced low, forced high, and two direction-aware PWM shapes that are mirror images of each other.

A 16-bit control word holds one 8-bit configuration field per channel. The field selects output or input use, the compare behaviour, a preload shadow for the compare value, a shorter output latency, and whether the external clear acts on the channel. A compare value is written either straight into the active comparator or into a shadow that is copied across on the next update event. A small synchronous register port reads back the control word and both compare values.

Top module: `oc_pair`

## Requirements
- R1: While reset is asserted and right after it, the control word and both compare values read 0 and both reference outputs are 0.
- R2: Address 0 is the control word, address 1 is the compare value of channel 0, address 2 is that of channel 1, and address 3 reads 0. Channel 0 owns control bits 7:0 and channel 1 owns bits 15:8. Within its byte a channel has I/O select in bits 1:0, fast enable in bit 2, preload enable in bit 3, compare behaviour in bits 6:4 and clear enable in bit 7. A compare address reads back the last value written to it.
- R3: A nonzero I/O select makes the channel an input: its reference keeps its value whatever the counter, the clear input or the compare behaviour does.
- R4: Compare behaviour 1 drives the reference to 1, behaviour 2 drives it to 0, and behaviour 3 inverts it, each in a cycle where the counter equals the active compare value. Behaviour 0 leaves the reference unchanged.
- R5: Behaviour 4 holds the reference at 0 and behaviour 5 holds it at 1, without waiting for a match.
- R6: Behaviour 6 with cnt_down at 0 gives 1 while the counter is below the compare value and 0 otherwise. With cnt_down at 1 it gives 0 while the counter is above the compare value and 1 otherwise.
- R7: Behaviour 7 gives the inverse of behaviour 6 for the same counter, direction and compare value.
- R8: With preload disabled, a compare write reaches the active comparator at the same clock edge that stores it.
- R9: With preload enabled, a compare write reaches only the shadow, and each update event copies the shadow into the active comparator. A write coinciding with an update event lets the previous shadow value through; the new value waits for the next update event.
- R10: The reference core samples its inputs at an edge. With fast enable 0 the result appears on ref_out four edges later, so five edges in all. With fast enable 1 it appears two edges later, three in all. Toggling fast enable changes which stage drives ref_out without a clock.
- R11: When a channel's clear enable is 1 and clr_in is 1, its reference becomes 0. It stays 0 until an update event arrives while clr_in is 0, and then follows the compare behaviour again from the next edge.
- R12: A control-word write takes effect at the clock edge after the write edge. Behaviours and options read at the write edge are the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| upd_evt | input | 1 | Single-cycle update-event pulse |
| clr_in | input | 1 | External reference clear request |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8*CH_N | Write data |
| bus_rdata | output | 8*CH_N | Read data for bus_addr |
| ref_out | output | CH_N | Delayed reference output, one bit per channel |

## Verification
Two pairs of functions can fall in the same cycle. A preloaded compare write can land on the edge of an update event, and the clear request can be high on the edge of an update event. The bench provokes both by driving bus_we or clr_in together with an extra update pulse in one cycle. Its behavioural model holds separate shadow, active and clear-hold state, so it predicts that the old shadow is copied and that the clear is still in force. Every cycle the model's prediction of ref_out and of the read data is compared with the design.

// File: rtl/oc_pair_pkg.sv
package oc_pair_pkg;

   localparam int CFG_W = 8;

   typedef enum logic [2:0] {
      CM_FROZEN     = 3'd0,
      CM_SET_ON_EQ  = 3'd1,
      CM_CLR_ON_EQ  = 3'd2,
      CM_FLIP_ON_EQ = 3'd3,
      CM_FORCE_LO   = 3'd4,
      CM_FORCE_HI   = 3'd5,
      CM_PWM_A      = 3'd6,
      CM_PWM_B      = 3'd7
   } cmp_mode_e;

   typedef struct packed {
      logic      clr_en;
      cmp_mode_e mode;
      logic      pre_en;
      logic      fast_en;
      logic [1:0] io_sel;
   } chan_cfg_t;

endpackage

// File: rtl/oc_regfile.sv
module oc_regfile
   import oc_pair_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int CH_N   = 2,
   parameter int ADDR_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_evt,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_we,
   input  logic [CH_N*CFG_W-1:0]   bus_wdata,
   output logic [CH_N*CFG_W-1:0]   bus_rdata,
   output chan_cfg_t               cfg_o    [CH_N],
   output logic [CNT_W-1:0]        active_o [CH_N]
);

   localparam int BUS_W = CH_N * CFG_W;

   logic [BUS_W-1:0] ctl_q;
   logic [CNT_W-1:0] shadow_q [CH_N];
   logic [CNT_W-1:0] active_q [CH_N];
   logic [CH_N-1:0]  wr_hit;

   always_comb begin
      for (int ch = 0; ch < CH_N; ch++) begin
         wr_hit[ch] = bus_we && (bus_addr == ADDR_W'(ch + 1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (bus_we && (bus_addr == '0)) begin
         ctl_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int ch = 0; ch < CH_N; ch++) begin
            shadow_q[ch] <= '0;
            active_q[ch] <= '0;
         end
      end else begin
         for (int ch = 0; ch < CH_N; ch++) begin
            if (wr_hit[ch]) begin
               shadow_q[ch] <= bus_wdata[CNT_W-1:0];
            end
            if (cfg_o[ch].pre_en) begin
               if (upd_evt) begin
                  active_q[ch] <= shadow_q[ch];
               end
            end else if (wr_hit[ch]) begin
               active_q[ch] <= bus_wdata[CNT_W-1:0];
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) begin
         bus_rdata = ctl_q;
      end
      for (int ch = 0; ch < CH_N; ch++) begin
         if (bus_addr == ADDR_W'(ch + 1)) begin
            bus_rdata = BUS_W'(shadow_q[ch]);
         end
      end
   end

   for (genvar g = 0; g < CH_N; g++) begin : g_chan
      assign cfg_o[g]    = chan_cfg_t'(ctl_q[g*CFG_W +: CFG_W]);
      assign active_o[g] = active_q[g];

      AST_SHADOW_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_o[g].pre_en && !upd_evt) |=> $stable(active_q[g])); // R9
      AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_o[g].pre_en && upd_evt) |=> (active_q[g] == $past(shadow_q[g]))); // R9
      AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_o[g].pre_en && wr_hit[g]) |=> (active_q[g] == $past(bus_wdata[CNT_W-1:0]))); // R8
   end

endmodule

// File: rtl/oc_ref_engine.sv
module oc_ref_engine
   import oc_pair_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cfg_t        cfg,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic             upd_evt,
   input  logic             clr_in,
   output logic             ref_q
);

   logic ref_d;
   logic hold_q, hold_d;
   logic matched, below, above, pwm_a, blocked, is_out;

   always_comb begin
      matched = (cnt_val == cmp_val);
      below   = (cnt_val <  cmp_val);
      above   = (cnt_val >  cmp_val);
      pwm_a   = cnt_down ? !above : below;
      is_out  = (cfg.io_sel == 2'd0);
      blocked = cfg.clr_en && (clr_in || hold_q);
   end

   always_comb begin
      ref_d = ref_q;
      if (is_out) begin
         if (blocked) begin
            ref_d = 1'b0;
         end else begin
            unique case (cfg.mode)
               CM_FROZEN:     ref_d = ref_q;
               CM_SET_ON_EQ:  ref_d = matched ? 1'b1 : ref_q;
               CM_CLR_ON_EQ:  ref_d = matched ? 1'b0 : ref_q;
               CM_FLIP_ON_EQ: ref_d = matched ? !ref_q : ref_q;
               CM_FORCE_LO:   ref_d = 1'b0;
               CM_FORCE_HI:   ref_d = 1'b1;
               CM_PWM_A:      ref_d = pwm_a;
               CM_PWM_B:      ref_d = !pwm_a;
               default:       ref_d = ref_q;
            endcase
         end
      end
   end

   always_comb begin
      if (cfg.clr_en && clr_in) begin
         hold_d = 1'b1;
      end else if (upd_evt) begin
         hold_d = 1'b0;
      end else begin
         hold_d = hold_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         ref_q  <= ref_d;
         hold_q <= hold_d;
      end
   end

   AST_INPUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !is_out |=> $stable(ref_q)); // R3
   AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && cfg.mode == CM_FORCE_LO) |=> !ref_q); // R5
   AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && !blocked && cfg.mode == CM_FORCE_HI) |=> ref_q); // R5
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && cfg.clr_en && clr_in) |=> !ref_q); // R11
   AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && !blocked && cfg.mode == CM_SET_ON_EQ && matched) |=> ref_q); // R4
   AST_PWM_UP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out && !blocked && cfg.mode == CM_PWM_A && !cnt_down && !below) |=> !ref_q); // R6

endmodule

// File: rtl/oc_out_delay.sv
module oc_out_delay #(
   parameter int SLOW_LAT = 5,
   parameter int FAST_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fast_sel,
   output logic dout
);

   localparam int DEPTH = SLOW_LAT - 1;

   logic slow_tap, fast_tap;

   if (DEPTH == 0) begin : g_direct
      assign slow_tap = din;
      assign fast_tap = din;
   end else begin : g_pipe
      logic [DEPTH-1:0] pipe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q <= '0;
         end else begin
            pipe_q <= (pipe_q << 1) | DEPTH'(din);
         end
      end

      assign slow_tap = pipe_q[DEPTH-1];

      if (FAST_LAT == 1) begin : g_fast_direct
         assign fast_tap = din;
      end else begin : g_fast_tap
         assign fast_tap = pipe_q[FAST_LAT-2];
      end
   end

   assign dout = fast_sel ? fast_tap : slow_tap;

endmodule

// File: rtl/oc_pair.sv
module oc_pair
   import oc_pair_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int CH_N     = 2,
   parameter int SLOW_LAT = 5,
   parameter int FAST_LAT = 3,
   parameter int ADDR_W   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CNT_W-1:0]      cnt_val,
   input  logic                  cnt_down,
   input  logic                  upd_evt,
   input  logic                  clr_in,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [CH_N*CFG_W-1:0] bus_wdata,
   output logic [CH_N*CFG_W-1:0] bus_rdata,
   output logic [CH_N-1:0]       ref_out
);

   localparam int BUS_W    = CH_N * CFG_W;
   localparam int ADDR_MIN = $clog2(CH_N + 2);

   if (CNT_W > BUS_W) begin : g_bad_width
      $error("compare width exceeds bus width");
   end
   if (ADDR_W < ADDR_MIN) begin : g_bad_addr
      $error("address too narrow for the channel count");
   end
   if (FAST_LAT < 1 || FAST_LAT > SLOW_LAT) begin : g_bad_lat
      $error("fast latency must lie between 1 and the slow latency");
   end

   chan_cfg_t        cfg    [CH_N];
   logic [CNT_W-1:0] active [CH_N];
   logic [CH_N-1:0]  ref_core;

   oc_regfile #(
      .CNT_W  (CNT_W),
      .CH_N   (CH_N),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_evt   (upd_evt),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_o     (cfg),
      .active_o  (active)
   );

   for (genvar g = 0; g < CH_N; g++) begin : g_ch
      oc_ref_engine #(
         .CNT_W (CNT_W)
      ) u_engine (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cfg[g]),
         .cmp_val  (active[g]),
         .cnt_val  (cnt_val),
         .cnt_down (cnt_down),
         .upd_evt  (upd_evt),
         .clr_in   (clr_in),
         .ref_q    (ref_core[g])
      );

      oc_out_delay #(
         .SLOW_LAT (SLOW_LAT),
         .FAST_LAT (FAST_LAT)
      ) u_delay (
         .clk      (clk),
         .rst_n    (rst_n),
         .din      (ref_core[g]),
         .fast_sel (cfg[g].fast_en),
         .dout     (ref_out[g])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (ref_out == '0)); // R1

endmodule

// File: tb/tb_oc_pair.sv
module tb_oc_pair;

   localparam int PER = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cnt_val;
   logic        cnt_down;
   logic        upd_evt;
   logic        clr_in;
   logic [1:0]  bus_addr;
   logic        bus_we;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic [1:0]  ref_out;

   oc_pair dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_val   (cnt_val),
      .cnt_down  (cnt_down),
      .upd_evt   (upd_evt),
      .clr_in    (clr_in),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ref_out   (ref_out)
   );

   always #10ns clk = ~clk;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    run_en   = 0;
   bit    finished = 0;
   string tag      = "R1";

   // behavioural reference state
   int unsigned m_ctl = 0;
   int  m_shadow [2] = '{0, 0};
   int  m_active [2] = '{0, 0};
   bit  m_core   [2] = '{0, 0};
   bit  m_hold   [2] = '{0, 0};
   bit  m_hist   [2][5];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 0;
         for (int c = 0; c < 2; c++) begin
            m_shadow[c] = 0; m_active[c] = 0; m_core[c] = 0; m_hold[c] = 0;
            for (int i = 0; i < 5; i++) m_hist[c][i] = 0;
         end
      end else begin
         int unsigned old_ctl;
         old_ctl = m_ctl;
         for (int c = 0; c < 2; c++) begin
            int  cfg, io, mode, cnt, cmp;
            bit  pre, ce, blocked, nc, pa;
            cfg  = (old_ctl >> (8 * c)) & 8'hFF;
            io   = cfg & 3;
            pre  = cfg[3];
            mode = (cfg >> 4) & 7;
            ce   = cfg[7];
            cnt  = cnt_val;
            cmp  = m_active[c];
            blocked = ce && (clr_in || m_hold[c]);
            pa = cnt_down ? (cnt <= cmp) : (cnt < cmp);
            nc = m_core[c];
            if (io == 0) begin
               if (blocked) nc = 0;
               else case (mode)
                  1: if (cnt == cmp) nc = 1;
                  2: if (cnt == cmp) nc = 0;
                  3: if (cnt == cmp) nc = !m_core[c];
                  4: nc = 0;
                  5: nc = 1;
                  6: nc = pa;
                  7: nc = !pa;
                  default: nc = m_core[c];
               endcase
            end
            if (ce && clr_in) m_hold[c] = 1;
            else if (upd_evt) m_hold[c] = 0;
            if (pre) begin
               if (upd_evt) m_active[c] = m_shadow[c];
            end else if (bus_we && bus_addr == 2'(c + 1)) begin
               m_active[c] = bus_wdata;
            end
            if (bus_we && bus_addr == 2'(c + 1)) m_shadow[c] = bus_wdata;
            m_core[c] = nc;
            for (int i = 4; i > 0; i--) m_hist[c][i] = m_hist[c][i-1];
            m_hist[c][0] = nc;
         end
         if (bus_we && bus_addr == 2'd0) m_ctl = bus_wdata;
      end
   end

   // compare every cycle, a quarter period after the rising edge
   always @(posedge clk) begin
      #5ns;
      if (!finished) begin
         int exp_rd;
         for (int c = 0; c < 2; c++) begin
            bit fast, exp_o;
            fast  = m_ctl[8*c + 2];
            exp_o = fast ? m_hist[c][2] : m_hist[c][4];
            n_checks++;
            if (ref_out[c] !== exp_o) begin
               n_fail++;
               $display("FAIL %s ch%0d ref_out actual=%b expected=%b at %0t", tag, c, ref_out[c], exp_o, $time);
            end
         end
         case (bus_addr)
            2'd0: exp_rd = m_ctl;
            2'd1: exp_rd = m_shadow[0];
            2'd2: exp_rd = m_shadow[1];
            default: exp_rd = 0;
         endcase
         n_checks++;
         if (bus_rdata !== 16'(exp_rd)) begin
            n_fail++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, bus_addr, bus_rdata, 16'(exp_rd));
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      bus_we  = 0;
      upd_evt = 0;
      if (run_en) begin
         if (!cnt_down) begin
            if (cnt_val == 16'(PER - 1)) begin cnt_val = 0; upd_evt = 1; end
            else cnt_val = cnt_val + 1;
         end else begin
            if (cnt_val == 0) begin cnt_val = 16'(PER - 1); upd_evt = 1; end
            else cnt_val = cnt_val - 1;
         end
      end
   endtask

   task automatic ticks(int n);
      repeat (n) tick();
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      tick();
      bus_we = 1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      wrap_up();
   end

   initial begin
      rst_n = 0; cnt_val = 0; cnt_down = 0; upd_evt = 0; clr_in = 0;
      bus_addr = 0; bus_we = 0; bus_wdata = 0;
      // R1: reset state
      tag = "R1";
      ticks(4);
      bus_addr = 1; ticks(1); bus_addr = 2; ticks(1); bus_addr = 0;
      rst_n = 1;
      ticks(3);

      // R2: register map and readback
      tag = "R2";
      wr(1, 16'd5); wr(2, 16'd14);
      tick(); bus_addr = 1; tick(); bus_addr = 2; tick(); bus_addr = 3;
      wr(0, 16'hF3E7); tick(); bus_addr = 0; ticks(2);
      wr(0, 16'h0000); ticks(2);

      run_en = 1;
      // R4: match-driven behaviours
      tag = "R4";
      wr(0, 16'h3010); ticks(45);
      wr(0, 16'h2020); ticks(25);
      wr(0, 16'h0000); ticks(25);

      // R5: forced levels
      tag = "R5";
      wr(0, 16'h5040); ticks(10);
      wr(0, 16'h4050); ticks(10);

      // R12: control write applies at the next edge
      tag = "R12";
      wr(0, 16'h0050); ticks(6);
      wr(0, 16'h0040); ticks(6);

      // R6: PWM behaviour 6, both directions
      tag = "R6";
      wr(0, 16'h6060); ticks(45);
      cnt_down = 1; ticks(45);

      // R7: PWM behaviour 7
      tag = "R7";
      wr(0, 16'h7070); ticks(45);
      cnt_down = 0; ticks(45);

      // R10: latency selection
      tag = "R10";
      wr(0, 16'h6464); ticks(30);
      wr(0, 16'h6460); ticks(30);
      wr(0, 16'h6064); ticks(30);

      // R8: direct compare writes
      tag = "R8";
      wr(1, 16'd3); wr(2, 16'd17); ticks(30);
      wr(1, 16'd0); wr(2, 16'd20); ticks(30);

      // R9: preload shadow, including write coinciding with update
      tag = "R9";
      wr(0, 16'h6868); wr(1, 16'd10); ticks(10);
      tick(); upd_evt = 1; bus_we = 1; bus_addr = 1; bus_wdata = 16'd2;
      ticks(30);
      tick(); upd_evt = 1; ticks(30);

      // R11: clear with hold until update
      tag = "R11";
      wr(0, 16'h60E0); wr(1, 16'd15); tick(); upd_evt = 1; ticks(10);
      clr_in = 1; ticks(3); clr_in = 0; ticks(30);
      tick(); clr_in = 1; upd_evt = 1; tick(); clr_in = 0; ticks(8);
      tick(); upd_evt = 1; ticks(20);

      // R3: input mode holds the reference
      tag = "R3";
      wr(0, 16'h6061); ticks(30);
      wr(0, 16'h63E2); clr_in = 1; ticks(10); clr_in = 0; ticks(10);
      wr(0, 16'h6060); ticks(20);

      // mixed traffic across preload, clear and all behaviours
      tag = "R9";
      for (int k = 0; k < 1500; k++) begin
         int r;
         tick();
         r = $urandom_range(0, 99);
         if (r < 4) begin
            logic [15:0] d;
            d = 16'($urandom);
            if ($urandom_range(0, 5) != 0) d[1:0] = 0;
            if ($urandom_range(0, 5) != 0) d[9:8] = 0;
            bus_we = 1; bus_addr = 0; bus_wdata = d;
         end else if (r < 12) begin
            bus_we = 1; bus_addr = 2'($urandom_range(1, 2));
            bus_wdata = 16'($urandom_range(0, PER));
         end else if (r < 15) begin
            bus_addr = 2'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 29) == 0) upd_evt = 1;
         if ($urandom_range(0, 24) == 0) clr_in = !clr_in;
         if ($urandom_range(0, 99) == 0) cnt_down = !cnt_down;
      end
      clr_in = 0;
      ticks(10);
      wrap_up();
   end

endmodule